// File: doc/BRIEF.md
# Edge-Triggered Timestamp Capture Unit

This block records when things happen on a set of input pins. A free-running counter comes in from outside the block. When a chosen transition appears on a channel's pin, the counter's current value is stored in that channel's capture register. Each channel has a 2-bit code that selects which transition counts: none, rising, falling, or both. A capture also raises that channel's bit in a shared event-flag register. Software clears a flag by writing 1 to its bit. A single interrupt line goes high while any flag is set and that channel's mask bit is also set.

The last channel can work in one of two ways. A mode bit selects its role. In capture mode it works like every other channel. In compare mode its 16-bit register holds a compare value that software writes, and its flag is raised when the counter equals that value. In compare mode the pin is ignored.

Pins are asynchronous, so each one passes through two synchronizing flops before edge detection. Software reaches the block through a single-cycle write port and a combinational read port that share one address bus.

Top module: `incap_unit`

## Requirements
- R1: A pin change that is present before clock edge k is loaded into the capture register at edge k+2. The value loaded is the counter input present at edge k+2.
- R2: The edge code of channel i is in bits [2i+1:2i] of the edge register (address 0). Code 00 disables capture, 01 captures rising edges, 10 captures falling edges, and 11 captures both.
- R3: A capture sets bit i of the flag register (address 1).
- R4: Writing 1 to a bit of the flag register clears that flag. Writing 0 to a bit leaves that flag unchanged.
- R5: If a flag-clearing write and a new capture on the same channel fall on the same clock edge, the flag stays set.
- R6: A capture while the flag is already set overwrites the capture register with the new counter value, and the flag stays set.
- R7: irq_o is high exactly when some channel has both its flag bit and its mask bit (address 2, bit i) set.
- R8: Bit 0 of the mode register (address 3) sets the role of the last channel: 0 selects compare and 1 selects capture. In compare mode, pin edges are ignored, the channel's register is writable, and the flag is raised on the cycle the counter equals the register.
- R9: Capture registers are at address 4+i. Software writes to a register in capture mode are ignored.
- R10: After reset, all registers read 0, the last channel is in compare mode, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Free-running counter value |
| pin_i | input | 4 | Asynchronous event pins, one per channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check three things:
- a detected event loads the counter value from that same cycle and sets the flag on the next edge;
- a flag falls only after a write of 1 to its bit, and a set request wins over a clear on the same edge;
- the interrupt is never high while every mask bit is zero.

Some behaviour can only be shown through the bench's pin sequences. The bench demonstrates the two-cycle synchronizer latency, the decoding of each edge code in both directions, the overwrite of a still-pending capture, and the switch of the shared channel between compare matching and capture.

// File: rtl/incap_unit.sv
module incap_unit #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = 4,
  parameter int SHR = NCH - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic [NCH-1:0] pin_i,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          irq_o
);
  localparam int A_EDGE = 0;
  localparam int A_FLAG = 1;
  localparam int A_MASK = 2;
  localparam int A_MODE = 3;
  localparam int A_CAP0 = 4;

  logic [2*NCH-1:0] esel_q;
  logic [NCH-1:0]   flag_q, mask_q;
  logic             mode_q;
  logic [NCH-1:0]   s1, s2, s3;
  logic [NCH-1:0]   cap_evt, set_v;
  logic [NCH*CW-1:0] cap_flat;

  wire we_edge = wr_en && addr == AW'(A_EDGE);
  wire we_flag = wr_en && addr == AW'(A_FLAG);
  wire we_mask = wr_en && addr == AW'(A_MASK);
  wire we_mode = wr_en && addr == AW'(A_MODE);
  wire [NCH-1:0] clr_v = we_flag ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s3, s2, s1} <= '0;
    else        {s3, s2, s1} <= {s2, s1, pin_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      esel_q <= '0;
      mask_q <= '0;
      mode_q <= 1'b0;
      flag_q <= '0;
    end else begin
      if (we_edge) esel_q <= wdata[2*NCH-1:0];
      if (we_mask) mask_q <= wdata[NCH-1:0];
      if (we_mode) mode_q <= wdata[0];
      flag_q <= (flag_q & ~clr_v) | set_v;
    end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam bit SH = (i == SHR);
    logic [CW-1:0] cap_r;
    logic hit;
    wire rise = s2[i] & ~s3[i];
    wire fall = ~s2[i] & s3[i];
    wire we_cap = wr_en && addr == AW'(A_CAP0 + i);

    always_comb
      case (esel_q[2*i +: 2])
        2'b01:   hit = rise;
        2'b10:   hit = fall;
        2'b11:   hit = rise | fall;
        default: hit = 1'b0;
      endcase

    if (SH) begin : g_shared
      assign cap_evt[i] = mode_q & hit;
      assign set_v[i]   = cap_evt[i] | (!mode_q && cnt_i == cap_r);
    end else begin : g_plain
      assign cap_evt[i] = hit;
      assign set_v[i]   = hit;
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                      cap_r <= '0;
      else if (cap_evt[i])             cap_r <= cnt_i;
      else if (SH && !mode_q && we_cap) cap_r <= wdata;

    assign cap_flat[i*CW +: CW] = cap_r;

    assert_capval_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[i] |=> cap_r == $past(cnt_i));
    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[i] |=> flag_q[i]);
    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[i]) |-> $past(we_flag && wdata[i]));
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v[i] && clr_v[i]) |=> flag_q[i]);
  end

  assign irq_o = |(flag_q & mask_q);

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |mask_q);

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(A_EDGE): rdata = CW'(esel_q);
      AW'(A_FLAG): rdata = CW'(flag_q);
      AW'(A_MASK): rdata = CW'(mask_q);
      AW'(A_MODE): rdata = CW'(mode_q);
      default:
        for (int k = 0; k < NCH; k++)
          if (addr == AW'(A_CAP0 + k)) rdata = cap_flat[k*CW +: CW];
    endcase
  end
endmodule

// File: tb/sim_incap_unit.sv
module sim_incap_unit;
  logic        clk = 0, rst_n = 0;
  logic [15:0] cnt = 16'h1000;
  logic [3:0]  pin = '0;
  logic        wr_en = 0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  incap_unit u0 (.clk(clk), .rst_n(rst_n), .cnt_i(cnt), .pin_i(pin), .wr_en(wr_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq));

  always #10 clk = ~clk;
  always @(negedge clk) cnt <= cnt + 16'd1;

  // {ch[1:0], code[1:0], from, to, expect_capture}
  localparam logic [6:0] VEC [8] = '{
    {2'd0, 2'b01, 1'b0, 1'b1, 1'b1},
    {2'd0, 2'b01, 1'b1, 1'b0, 1'b0},
    {2'd1, 2'b10, 1'b1, 1'b0, 1'b1},
    {2'd1, 2'b10, 1'b0, 1'b1, 1'b0},
    {2'd2, 2'b11, 1'b0, 1'b1, 1'b1},
    {2'd2, 2'b11, 1'b1, 1'b0, 1'b1},
    {2'd0, 2'b00, 1'b0, 1'b1, 1'b0},
    {2'd1, 2'b00, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); #1;
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic move(int ch, logic lvl, output logic [15:0] v);
    @(negedge clk); #1;
    pin[ch] = lvl; v = cnt;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] d, v, c;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;

    // R10 reset state
    rd(0, d); check("R10 edge", d, 0);
    rd(1, d); check("R10 flag", d, 0);
    rd(2, d); check("R10 mask", d, 0);
    rd(3, d); check("R10 mode", d, 0);
    rd(4, d); check("R10 cap0", d, 0);
    check("R10 irq", {15'd0, irq}, 0);

    // R1 R2 R3 table walk
    for (int n = 0; n < 8; n++) begin
      int ch; logic [1:0] code;
      ch = int'(VEC[n][6:5]); code = VEC[n][4:3];
      wr(0, 16'h0);
      @(negedge clk); #1; pin[ch] = VEC[n][2];
      repeat (4) @(posedge clk);
      wr(1, 16'h000F);
      wr(0, 16'(code) << (2*ch));
      move(ch, VEC[n][1], v);
      rd(1, d); check("R2 R3 flag on edge code", 16'(d[ch]), 16'(VEC[n][0]));
      if (VEC[n][0]) begin
        rd(4'(4 + ch), d); check("R1 captured value", d, v + 16'd2);
      end
    end

    // R4 write-one-to-clear
    wr(0, 16'h0001); pin = '0;
    repeat (4) @(posedge clk);
    wr(1, 16'h000F);
    move(0, 1'b1, v);
    wr(1, 16'h0000);
    rd(1, d); check("R4 write zero keeps flag", 16'(d[0]), 1);
    wr(1, 16'h0001);
    rd(1, d); check("R4 write one clears flag", 16'(d[0]), 0);

    // R6 overwrite while pending
    wr(0, 16'h0003);
    move(0, 1'b0, v);
    move(0, 1'b1, c);
    rd(4, d); check("R6 overwrite value", d, c + 16'd2);
    rd(1, d); check("R6 flag stays set", 16'(d[0]), 1);

    // R7 interrupt masking (flag0 set)
    wr(2, 16'h0002);
    check("R7 irq other mask", {15'd0, irq}, 0);
    wr(2, 16'h0001);
    check("R7 irq enabled", {15'd0, irq}, 1);
    wr(2, 16'h0000);
    check("R7 irq masked", {15'd0, irq}, 0);

    // R5 clear on the capture edge
    @(negedge clk); #1; pin[0] = 1'b0; v = cnt;
    @(posedge clk); @(posedge clk);
    @(negedge clk); #1; wr_en = 1; addr = 1; wdata = 16'h0001;
    @(posedge clk);
    @(negedge clk); #1; wr_en = 0;
    rd(1, d); check("R5 set beats clear", 16'(d[0]), 1);
    rd(4, d); check("R5 captured value", d, v + 16'd2);

    // R8 compare mode on shared channel 3
    wr(1, 16'h000F);
    wr(0, 16'h00C0);
    c = cnt + 16'd20;
    wr(7, c);
    rd(7, d); check("R8 compare reg writable", d, c);
    rd(1, d); check("R8 no early match", 16'(d[3]), 0);
    repeat (30) @(posedge clk);
    @(negedge clk); #1;
    rd(1, d); check("R8 compare match flag", 16'(d[3]), 1);
    wr(1, 16'h0008);
    move(3, 1'b1, v);
    rd(1, d); check("R8 pin ignored in compare", 16'(d[3]), 0);
    rd(7, d); check("R8 reg kept in compare", d, c);
    wr(3, 16'h0001);
    move(3, 1'b0, v);
    rd(7, d); check("R8 capture in capture mode", d, v + 16'd2);
    rd(1, d); check("R8 flag in capture mode", 16'(d[3]), 1);

    // R9 writes to capture registers ignored
    c = d;
    wr(7, 16'hBEEF);
    rd(7, d); check("R9 shared write ignored", d, v + 16'd2);
    rd(4, c);
    wr(4, 16'h1234);
    rd(4, d); check("R9 ch0 write ignored", d, c);

    finish_run();
  end
endmodule